// File: doc/BRIEF.md
# Pipelined No-Turnaround Synchronous SRAM

This block models a synchronous static RAM that can take a read or a write on every enabled clock edge with no idle cycles between them. Each command is sampled at one clock edge. Its data moves on the bus one full clock later, so the bus traffic for a command issued at edge n is complete at edge n+2. Reads and writes both use this same offset. A write followed at once by a read, or a read followed at once by a write, therefore needs no bus turnaround gap.

Each command either loads a fresh address or advances a 2-bit burst counter. The counter can step in linear (wrapping add) order or in interleaved (XOR) order. An advance cycle repeats whatever the previous cycle was: a read, a write, or a deselect. Writes are masked per 9-bit byte. A read of a word whose write is still in flight in the data pipeline returns the merged new bytes. The read data bus has a valid flag that is gated by an asynchronous output enable. A clock enable freezes the whole block for as long as it is deasserted.

Top module: `pipe_sram`

## Requirements
- R1: While `clk_en_n` is sampled high, the edge is a hold. No memory word, burst state, pipeline stage or read output changes, whatever the other inputs are. A write whose data phase was pending completes at the next enabled edge instead.
- R2: The chip counts as selected only when `sel1_n` is 0, `sel2` is 1 and `sel3_n` is 0 at the edge. If any one of the three is wrong, a load cycle neither reads nor writes.
- R3: On a load cycle (`ld_n` = 0), the command is decided as follows. A deselected chip gives an idle cycle. A selected chip with `we_n` = 0 starts a write at `addr`. A selected chip with `we_n` = 1 starts a read at `addr`.
- R4: On an advance cycle (`ld_n` = 1), the previous cycle's type is repeated (read, write or idle) at the next burst address. On such a cycle `addr`, `we_n` and the three selects are ignored.
- R5: With `burst_ilv` = 0, the two low address bits of step k of a burst are (start + k) mod 4. The upper bits stay at the loaded value. For example, a start of 01 gives 01, 10, 11, 00.
- R6: With `burst_ilv` = 1, the two low address bits of step k are start XOR k. For example, a start of 01 gives 01, 00, 11, 10.
- R7: `be_n[b]` = 0 enables byte b, which is `wdata[9b+8:9b]` / `rdata[9b+8:9b]`. A write changes only its enabled bytes. Byte enables have no effect on reads. A write with no byte enabled still loads the address, and a burst write with no byte enabled still advances the counter.
- R8: For a command sampled at enabled edge n, the bus traffic completes at enabled edge n+2. A read's word is on `rdata` with `rdata_oe` = 1 so that it can be sampled at edge n+2. A write's bytes are taken from `wdata` at edge n+2.
- R9: `oe_n` acts without a clock. When `oe_n` = 1, or when no read data phase is active, `rdata_oe` is 0 and `rdata` is all zeros.
- R10: A read issued on the cycle right after a write to the same word returns the bytes that write enabled, taken from its `wdata`. All other bytes come from memory.
- R11: After reset, `rdata_oe` is 0 and the cycle type is idle, so an advance cycle issued first produces no read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, synchronised inside |
| clk_en_n | input | 1 | Clock enable, active low; high makes the edge a hold |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| ld_n | input | 1 | 0 loads a new address and command, 1 advances the burst |
| we_n | input | 1 | Write strobe, active low, sampled on load cycles |
| be_n | input | DATA_W/9 | Per-byte write enables, active low |
| addr | input | ADDR_W | Word address, sampled on load cycles |
| burst_ilv | input | 1 | Static burst order: 0 linear, 1 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | DATA_W | Write data bus |
| rdata | output | DATA_W | Read data bus, zero when not driven |
| rdata_oe | output | 1 | High while `rdata` carries read data |

## Verification
Suppose the burst state or the pipeline tracks the wrong cycle type or address. The error does not show when the command is issued. It appears two enabled edges later, as read data from the wrong word or as a write landing in the wrong word, which only a later read exposes. A wrong hold or pipeline alignment shows at once as read data one slot early or late, or as a stray `rdata_oe`. A missing forward shows only when a read closely follows a write to the same word. The bench therefore compares every read slot against a reference memory that applies writes at their data phase. It also reads back every word after each byte-masked, burst or held write.

// File: rtl/pipe_sram_pkg.sv
`timescale 1ns/1ps
package pipe_sram_pkg;

  localparam int LANE_W = 9;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

  // Low two address bits for burst step 'step' from start 'start'.
  function automatic logic [1:0] burst_lsb(input logic [1:0] start,
                                           input logic [1:0] step,
                                           input logic       ilv);
    logic [1:0] r;
    if (ilv) r = start ^ step;
    else     r = start + step;
    return r;
  endfunction

endpackage

// File: rtl/pipe_sram_cmd.sv
`timescale 1ns/1ps
module pipe_sram_cmd
  import pipe_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NBYTE  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              sel1_n,
  input  logic              sel2,
  input  logic              sel3_n,
  input  logic              ld_n,
  input  logic              we_n,
  input  logic [NBYTE-1:0]  be_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ilv,
  output op_e               iss_op,
  output logic [ADDR_W-1:0] iss_addr,
  output logic [NBYTE-1:0]  iss_be
);

  op_e               last_q, last_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [1:0]        step_q, step_d;
  logic              chip_on;

  // Next-state: decode the command for this edge.
  always_comb begin
    chip_on = !sel1_n && sel2 && !sel3_n;
    if (!ld_n) begin
      base_d = addr;
      step_d = 2'd0;
      if (!chip_on)  last_d = OP_IDLE;
      else if (we_n) last_d = OP_RD;
      else           last_d = OP_WR;
    end else begin
      base_d = base_q;
      step_d = step_q + 2'd1;
      last_d = last_q;
    end
  end

  assign iss_op   = last_d;
  assign iss_addr = {base_d[ADDR_W-1:2], burst_lsb(base_d[1:0], step_d, ilv)};
  assign iss_be   = (last_d == OP_WR) ? ~be_n : '0;

  // State registers with explicit clock enable.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= OP_IDLE;
      base_q <= '0;
      step_q <= 2'd0;
    end else if (ce) begin
      last_q <= last_d;
      base_q <= base_d;
      step_q <= step_d;
    end
  end

  assert_hold_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> ($stable(last_q) && $stable(base_q) && $stable(step_q)));

endmodule

// File: rtl/pipe_sram_pipe.sv
`timescale 1ns/1ps
module pipe_sram_pipe
  import pipe_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NBYTE  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  op_e               iss_op,
  input  logic [ADDR_W-1:0] iss_addr,
  input  logic [NBYTE-1:0]  iss_be,
  output op_e               s1_op,
  output logic [ADDR_W-1:0] s1_addr,
  output op_e               s2_op,
  output logic [ADDR_W-1:0] s2_addr,
  output logic [NBYTE-1:0]  s2_be
);

  logic [NBYTE-1:0] s1_be;

  // Stage 1: command issued at the last enabled edge.
  // Stage 2: command issued two enabled edges ago (data phase now).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_op   <= OP_IDLE;
      s1_addr <= '0;
      s1_be   <= '0;
      s2_op   <= OP_IDLE;
      s2_addr <= '0;
      s2_be   <= '0;
    end else if (ce) begin
      s1_op   <= iss_op;
      s1_addr <= iss_addr;
      s1_be   <= iss_be;
      s2_op   <= s1_op;
      s2_addr <= s1_addr;
      s2_be   <= s1_be;
    end
  end

  assert_hold_pipe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> ($stable(s1_op) && $stable(s2_op) && $stable(s1_addr) && $stable(s2_addr)));

endmodule

// File: rtl/pipe_sram_store.sv
`timescale 1ns/1ps
module pipe_sram_store
  import pipe_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  op_e               s1_op,
  input  logic [ADDR_W-1:0] s1_addr,
  input  op_e               s2_op,
  input  logic [ADDR_W-1:0] s2_addr,
  input  logic [DATA_W/LANE_W-1:0] s2_be,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_q,
  output logic              rd_vld_q
);

  localparam int NBYTE = DATA_W / LANE_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] rd_word;
  logic [NBYTE-1:0]  fwd_hit;

  // One storage array per byte lane; the data-phase write and the
  // forward path for a read directly behind it.
  for (genvar b = 0; b < NBYTE; b++) begin : g_lane
    logic [LANE_W-1:0] lane_mem [DEPTH];
    logic [LANE_W-1:0] wbyte;

    assign wbyte      = wdata[b*LANE_W +: LANE_W];
    assign fwd_hit[b] = (s2_op == OP_WR) && s2_be[b] && (s2_addr == s1_addr);
    assign rd_word[b*LANE_W +: LANE_W] = fwd_hit[b] ? wbyte : lane_mem[s1_addr];

    always_ff @(posedge clk) begin
      if (ce && (s2_op == OP_WR) && s2_be[b]) begin
        lane_mem[s2_addr] <= wbyte;
      end
    end
  end

  // Registered read output.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q     <= '0;
      rd_vld_q <= 1'b0;
    end else if (ce) begin
      rd_vld_q <= (s1_op == OP_RD);
      if (s1_op == OP_RD) begin
        rd_q <= rd_word;
      end
    end
  end

  assert_read_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && s1_op == OP_RD) |=> rd_vld_q);

  assert_no_stray_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && s1_op != OP_RD) |=> !rd_vld_q);

  assert_forward_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && s1_op == OP_RD && s2_op == OP_WR && s2_addr == s1_addr && (&s2_be))
      |=> (rd_q == $past(wdata)));

endmodule

// File: rtl/pipe_sram.sv
`timescale 1ns/1ps
module pipe_sram
  import pipe_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 36
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clk_en_n,
  input  logic                     sel1_n,
  input  logic                     sel2,
  input  logic                     sel3_n,
  input  logic                     ld_n,
  input  logic                     we_n,
  input  logic [DATA_W/LANE_W-1:0] be_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     burst_ilv,
  input  logic                     oe_n,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        rdata,
  output logic                     rdata_oe
);

  localparam int NBYTE = DATA_W / LANE_W;

  logic [1:0]        rsync_q;
  logic              rst_q_n;
  logic              ce;
  op_e               iss_op, s1_op, s2_op;
  logic [ADDR_W-1:0] iss_addr, s1_addr, s2_addr;
  logic [NBYTE-1:0]  iss_be, s2_be;
  logic [DATA_W-1:0] rd_q;
  logic              rd_vld_q;

  // Reset asserts asynchronously, releases on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_q_n = rsync_q[1];
  assign ce      = !clk_en_n;

  pipe_sram_cmd #(.ADDR_W(ADDR_W), .NBYTE(NBYTE)) cmd_i (
    .clk(clk), .rst_n(rst_q_n), .ce(ce),
    .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
    .ld_n(ld_n), .we_n(we_n), .be_n(be_n), .addr(addr), .ilv(burst_ilv),
    .iss_op(iss_op), .iss_addr(iss_addr), .iss_be(iss_be)
  );

  pipe_sram_pipe #(.ADDR_W(ADDR_W), .NBYTE(NBYTE)) pipe_i (
    .clk(clk), .rst_n(rst_q_n), .ce(ce),
    .iss_op(iss_op), .iss_addr(iss_addr), .iss_be(iss_be),
    .s1_op(s1_op), .s1_addr(s1_addr),
    .s2_op(s2_op), .s2_addr(s2_addr), .s2_be(s2_be)
  );

  pipe_sram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) store_i (
    .clk(clk), .rst_n(rst_q_n), .ce(ce),
    .s1_op(s1_op), .s1_addr(s1_addr),
    .s2_op(s2_op), .s2_addr(s2_addr), .s2_be(s2_be),
    .wdata(wdata), .rd_q(rd_q), .rd_vld_q(rd_vld_q)
  );

  // Output enable acts without the clock.
  assign rdata_oe = rd_vld_q && !oe_n;
  assign rdata    = rdata_oe ? rd_q : '0;

  assert_burst_type_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ce && ld_n) |=> (s1_op == $past(s1_op)));

  assert_deselect_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ce && !ld_n && (sel1_n || !sel2 || sel3_n)) |=> (s1_op == OP_IDLE));

  assert_load_read_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ce && !ld_n && !sel1_n && sel2 && !sel3_n && we_n) |=> (s1_op == OP_RD));

endmodule

// File: tb/pipe_sram_tb_top.sv
`timescale 1ns/1ps
module pipe_sram_tb_top;
  localparam int AW = 6;
  localparam int DW = 36;
  localparam int NB = 4;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, clk_en_n, sel1_n, sel2, sel3_n, ld_n, we_n, burst_ilv, oe_n;
  logic [NB-1:0] be_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;
  logic rdata_oe;

  pipe_sram #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sel1_n(sel1_n), .sel2(sel2),
    .sel3_n(sel3_n), .ld_n(ld_n), .we_n(we_n), .be_n(be_n), .addr(addr),
    .burst_ilv(burst_ilv), .oe_n(oe_n), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  logic [DW-1:0] ref_mem [DEPTH];
  logic [DW-1:0] exp_q[$];
  string         tag_q[$];
  int  checks = 0, fails = 0;
  bit  adv = 0, exp_pend = 0, done = 0;
  string cur_tag = "R8";

  // Bench model of burst state and the two data-phase slots.
  int m_last = 0;
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_step = 2'd0;
  int p1_op = 0, p2_op = 0;
  logic [AW-1:0] p1_a = '0, p2_a = '0;
  logic [NB-1:0] p1_be = '1, p2_be = '1;
  logic [DW-1:0] p1_d = '0, p2_d = '0;

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rnd();
    logic [63:0] t;
    t = {$urandom(), $urandom()};
    return t[DW-1:0];
  endfunction

  // One clock: drive a command, advance the model at the edge.
  task automatic cyc(input bit hold, input bit s1n, input bit s2v, input bit s3n,
                     input bit ldn, input bit wen, input logic [NB-1:0] ben,
                     input logic [AW-1:0] a, input logic [DW-1:0] d);
    int n_op;
    logic [AW-1:0] n_base, n_a;
    logic [1:0] n_step, lsb;
    clk_en_n = hold; sel1_n = s1n; sel2 = s2v; sel3_n = s3n;
    ld_n = ldn; we_n = wen; be_n = ben; addr = a;
    wdata = (p2_op == 2) ? p2_d : rnd();
    if (!ldn) begin
      n_base = a; n_step = 2'd0;
      if (!s1n && s2v && !s3n) n_op = wen ? 1 : 2;
      else n_op = 0;
    end else begin
      n_base = m_base; n_step = m_step + 2'd1; n_op = m_last;
    end
    lsb = burst_ilv ? (n_base[1:0] ^ n_step) : (n_base[1:0] + n_step);
    n_a = {n_base[AW-1:2], lsb};
    @(posedge clk);
    if (!hold) begin
      if (p2_op == 2)
        for (int b = 0; b < NB; b++)
          if (!p2_be[b]) ref_mem[p2_a][b*9 +: 9] = p2_d[b*9 +: 9];
      exp_pend = (p1_op == 1);
      if (p1_op == 1) begin
        exp_q.push_back(ref_mem[p1_a]);
        tag_q.push_back(cur_tag);
      end
      p2_op = p1_op; p2_a = p1_a; p2_be = p1_be; p2_d = p1_d;
      p1_op = n_op;  p1_a = n_a;  p1_be = ben;   p1_d = d;
      m_last = n_op; m_base = n_base; m_step = n_step;
      adv = 1;
    end else begin
      adv = 0; exp_pend = 0;
    end
    #0.5;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [NB-1:0] ben, input logic [DW-1:0] d);
    cyc(0, 0, 1, 0, 0, 0, ben, a, d);
  endtask
  task automatic rd(input logic [AW-1:0] a);
    cyc(0, 0, 1, 0, 0, 1, '1, a, '0);
  endtask
  task automatic advc(input logic [NB-1:0] ben, input logic [DW-1:0] d);
    // Junk address, strobe and deselects must be ignored (R4).
    cyc(0, 1, 0, 1, 1, $urandom_range(0, 1) == 1, ben, AW'($urandom()), d);
  endtask
  task automatic idle();
    cyc(0, 1, 0, 1, 0, 1, '1, '0, '0);
  endtask

  // Scoreboard monitor: samples away from the active edge.
  always @(negedge clk) begin
    if (adv && !done) begin
      if (oe_n) begin
        check(!rdata_oe && rdata == '0, "R9", rdata, '0);
        if (exp_pend) begin
          void'(exp_q.pop_front());
          void'(tag_q.pop_front());
        end
      end else if (exp_pend) begin
        logic [DW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rdata_oe && rdata == e, t, rdata, e);
      end else begin
        check(!rdata_oe, "R8", {35'd0, rdata_oe}, '0);
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [DW-1:0] held;
    rst_n = 0; clk_en_n = 0; sel1_n = 1; sel2 = 0; sel3_n = 1; ld_n = 0; we_n = 1;
    be_n = '1; addr = '0; burst_ilv = 0; oe_n = 0; wdata = '0;
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    repeat (3) @(posedge clk);
    #0.5;
    check(!rdata_oe && rdata == '0, "R11", rdata, '0);
    rst_n = 1;
    repeat (3) @(posedge clk);
    #0.5;

    // R11: advance first after reset gives no read data.
    cur_tag = "R11";
    advc('0, rnd()); advc('0, rnd()); advc('0, rnd());
    check(!rdata_oe, "R11", {35'd0, rdata_oe}, '0);

    // Fill all words with 4-beat write bursts (all bytes).
    cur_tag = "R3";
    for (int base = 0; base < DEPTH; base += 4) begin
      wr(AW'(base), '0, rnd());
      for (int k = 0; k < 3; k++) advc('0, rnd());
    end
    idle(); idle();

    // R5: linear read bursts from non-zero starts, wrapping.
    cur_tag = "R5";
    for (int base = 0; base < DEPTH; base += 4) begin
      rd(AW'(base + (base / 4) % 4));
      for (int k = 0; k < 3; k++) advc('1, '0);
    end
    idle(); idle();

    // R6: interleaved write bursts, read back with single loads.
    burst_ilv = 1;
    cur_tag = "R6";
    for (int s = 1; s < 4; s++) begin
      wr(AW'(16 + 4*s + s), '0, rnd());
      for (int k = 0; k < 3; k++) advc('0, rnd());
    end
    idle(); idle();
    for (int i = 20; i < 32; i++) rd(AW'(i));
    for (int k = 0; k < 3; k++) advc('1, '0);
    idle(); idle();
    burst_ilv = 0;

    // R8/R10: alternating writes and reads, with same-word back-to-back.
    cur_tag = "R10";
    for (int i = 0; i < 40; i++) begin
      logic [AW-1:0] a;
      a = AW'($urandom_range(0, DEPTH-1));
      wr(a, NB'($urandom()), rnd());
      if (i % 2 == 0) rd(a);
      else rd(AW'($urandom_range(0, DEPTH-1)));
    end
    cur_tag = "R8";
    for (int i = 0; i < 20; i++) begin
      rd(AW'(i));
      wr(AW'(i + 1), '0, rnd());
    end
    idle(); idle();

    // R7: masks, empty write, burst advance with no bytes enabled.
    cur_tag = "R7";
    wr(6'd40, 4'b1111, rnd());
    wr(6'd41, 4'b1010, rnd());
    wr(6'd44, 4'b0110, rnd());
    advc(4'b1111, rnd());
    advc(4'b0000, rnd());
    idle(); idle();
    for (int i = 40; i < 48; i++) cyc(0, 0, 1, 0, 0, 1, NB'($urandom()), AW'(i), '0);
    idle(); idle();

    // R1: write held across holds with junk inputs, then read.
    cur_tag = "R1";
    wr(6'd50, '0, rnd());
    repeat (3) cyc(1, 0, 1, 0, 0, 0, '0, 6'd51, rnd());
    idle();
    repeat (2) cyc(1, 0, 1, 0, 0, 0, '0, 6'd52, rnd());
    idle();
    rd(6'd50); rd(6'd51); rd(6'd52);
    idle();
    held = rdata;
    for (int i = 0; i < 3; i++) begin
      cyc(1, 0, 1, 0, 0, 0, '0, 6'd50, rnd());
      check(rdata_oe && rdata == held, "R1", rdata, held);
    end
    idle(); idle(); idle();

    // R2: each select wrong alone on a would-be write.
    cur_tag = "R2";
    cyc(0, 1, 1, 0, 0, 0, '0, 6'd33, rnd());
    cyc(0, 0, 0, 0, 0, 0, '0, 6'd34, rnd());
    cyc(0, 0, 1, 1, 0, 0, '0, 6'd35, rnd());
    cyc(0, 1, 1, 0, 0, 1, '1, 6'd33, '0);
    idle(); idle();
    rd(6'd33); rd(6'd34); rd(6'd35);
    idle(); idle();

    // R4: deselect continued by advances; read burst with junk controls.
    cur_tag = "R4";
    idle(); advc('0, rnd()); advc('0, rnd());
    rd(6'd8); advc('0, rnd()); advc('0, rnd()); advc('0, rnd());
    idle(); idle();

    // R9: asynchronous output enable on a live read slot.
    cur_tag = "R9";
    rd(6'd12);
    idle();
    oe_n = 1; #0.2;
    check(!rdata_oe && rdata == '0, "R9", rdata, '0);
    oe_n = 0; #0.2;
    check(rdata_oe && rdata == ref_mem[12], "R9", rdata, ref_mem[12]);
    oe_n = 1;
    rd(6'd13); rd(6'd14); idle(); idle();
    oe_n = 0;
    idle(); idle(); idle();

    check(exp_q.size() == 0, "R8", DW'(exp_q.size()), '0);
    finish_run();
  end
endmodule